// File: doc/BRIEF.md
# 1-Wire Bus Reset and Presence Detector

This block starts a 1-Wire transaction by pulling the bus low for the reset interval and then releasing it. While the line is released it samples the bus at several fixed points and sorts the outcome into one of three results: a device answered with a presence pulse, nothing answered, or the bus is shorted. A short is recognised in two ways. The line may already be low at the moment a reset is requested, in which case no reset pulse is driven at all. The line may also still be low at the last sample point, later than any genuine presence pulse can last.

Timing is counted in microsecond ticks that are taken from the system clock. A speed-select input picks standard or overdrive timing, with overdrive at one tenth of the standard durations. The block keeps an effective-speed flag. That flag falls back to standard whenever a cycle ends with a short or with no device, because slaves leave overdrive after any long low or loss of contact. Between reset cycles the block polls the idle line at a fixed interval and pulses an arrival flag when a device announces itself with its own presence pulse.

Top module: `owrp_reset_presence`

## Requirements
- R1: After reset, drive_low, done and arrival are 0, result is 00 and od_active is 0.
- R2: When start is accepted with the line high, drive_low is asserted for exactly 480 µs at standard speed, or 48 µs when od_sel is 1.
- R3: done rises exactly (480+480) µs after an accepted start at standard speed, or (48+48) µs at overdrive, counted in clock cycles as microseconds times CLKS_PER_US.
- R4: Result code 01 (present) is given when the line was low at any early sample point and high at the last sample point. At standard speed the early points are 70, 130 and 190 µs after release and the last point is 300 µs; at overdrive they are 7, 13 and 19 µs and 30 µs.
- R5: Result code 00 (no device) is given when the line is high at every sample point.
- R6: Result code 10 (short) is given when the line is low at the last sample point. A presence pulse that ends before that point still gives 01. The code 11 is never produced.
- R7: If the line is low in the cycle that start is accepted, drive_low stays 0, done pulses on the next cycle and result is 10.
- R8: od_active takes the value of od_sel when a reset pulse is started, stays 1 only if the cycle ends with 01, and is cleared by a 00 or 10 result, including a short found by the pre-check.
- R9: While idle, the line is polled every POLL_US µs. A high-to-low change between two polls gives one single-cycle arrival pulse. No arrival is reported during a reset cycle.
- R10: A start strobe that arrives while a reset cycle is in progress is ignored: the timing and od_active of the running cycle are unchanged.
- R11: done is a single-cycle pulse. A start given in the same cycle as done is accepted, and drive_low rises on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a reset-and-presence cycle |
| od_sel | input | 1 | 1 selects overdrive timing for the requested cycle |
| line_in | input | 1 | Bus level as seen at the pin |
| drive_low | output | 1 | Enables the open-drain pulldown |
| result | output | 2 | 00 no device, 01 present, 10 short |
| done | output | 1 | One-cycle pulse when result is updated |
| arrival | output | 1 | One-cycle pulse on a spontaneous presence pulse while idle |
| od_active | output | 1 | Effective speed: 1 overdrive, 0 standard |

## Verification
The completion of one cycle and the acceptance of the next can fall in the same clock: done updates the result and returns the sequencer to idle on the same edge that a new start is sampled. The bench raises start in exactly the cycle where done is observed high. It then expects drive_low on the following cycle, a done pulse that lasts one cycle, and a second cycle with a clean result of its own. A start given during a running cycle is also provoked, with the opposite speed selected. It is judged by the unchanged total duration and the unchanged od_active.

// File: rtl/owrp_pkg.sv
package owrp_pkg;

  localparam int US_W = 10;
  typedef logic [US_W-1:0] us_t;

  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_PRESENT = 2'b01,
    RES_SHORT   = 2'b10
  } res_e;

  // Standard-speed durations in microseconds; overdrive divides by OD_DIV.
  localparam us_t STD_LOW  = us_t'(480);
  localparam us_t STD_REL  = us_t'(480);
  localparam us_t SMP_A    = us_t'(70);
  localparam us_t SMP_B    = us_t'(130);
  localparam us_t SMP_C    = us_t'(190);
  localparam us_t SMP_LAST = us_t'(300);
  localparam us_t OD_DIV   = us_t'(10);

  function automatic us_t scale(us_t t, logic od);
    return od ? us_t'(t / OD_DIV) : t;
  endfunction

  function automatic us_t low_len(logic od);
    return scale(STD_LOW, od);
  endfunction

  function automatic us_t rel_len(logic od);
    return scale(STD_REL, od);
  endfunction

  function automatic logic is_early_pt(us_t e, logic od);
    return (e == scale(SMP_A, od)) || (e == scale(SMP_B, od)) ||
           (e == scale(SMP_C, od));
  endfunction

  function automatic logic is_last_pt(us_t e, logic od);
    return e == scale(SMP_LAST, od);
  endfunction

  function automatic res_e classify(logic early_low, logic last_low);
    if (last_low)  return RES_SHORT;
    if (early_low) return RES_PRESENT;
    return RES_NONE;
  endfunction

endpackage

// File: rtl/owrp_tick.sv
module owrp_tick #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int TW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(CLKS_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/owrp_seq.sv
module owrp_seq
  import owrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic       od_sel,
  input  logic       line_hi,
  output logic       accept,
  output logic       busy,
  output logic       drive_low,
  output logic       done,
  output logic [1:0] result,
  output logic       od_active
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_REL} st_e;

  st_e  state;
  us_t  cnt;
  us_t  elapsed;
  logic speed_q;
  logic early_low;
  logic last_low;
  res_e res_q;
  res_e res_next;

  assign accept    = start && (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign drive_low = (state == S_LOW);
  assign elapsed   = cnt + us_t'(1);
  assign res_next  = classify(early_low, last_low);
  assign result    = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      speed_q   <= 1'b0;
      early_low <= 1'b0;
      last_low  <= 1'b0;
      res_q     <= RES_NONE;
      done      <= 1'b0;
      od_active <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            if (!line_hi) begin
              res_q     <= RES_SHORT;
              done      <= 1'b1;
              od_active <= 1'b0;
            end else begin
              state     <= S_LOW;
              speed_q   <= od_sel;
              od_active <= od_sel;
              cnt       <= '0;
              early_low <= 1'b0;
              last_low  <= 1'b0;
            end
          end
        end
        S_LOW: begin
          if (tick) begin
            if (cnt == low_len(speed_q) - us_t'(1)) begin
              state <= S_REL;
              cnt   <= '0;
            end else begin
              cnt <= elapsed;
            end
          end
        end
        S_REL: begin
          if (tick) begin
            cnt <= elapsed;
            if (is_early_pt(elapsed, speed_q) && !line_hi) early_low <= 1'b1;
            if (is_last_pt(elapsed, speed_q) && !line_hi)  last_low  <= 1'b1;
            if (elapsed == rel_len(speed_q)) begin
              state <= S_IDLE;
              res_q <= res_next;
              done  <= 1'b1;
              if (res_next != RES_PRESENT) od_active <= 1'b0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owrp_idle_watch.sv
module owrp_idle_watch #(
  parameter int POLL_US = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic busy,
  input  logic start,
  input  logic line_hi,
  output logic arrival
);
  localparam int PW = $clog2(POLL_US + 1);

  logic [PW-1:0] pcnt;
  logic          seen_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      seen_high <= 1'b0;
      arrival   <= 1'b0;
    end else if (busy || start) begin
      pcnt      <= '0;
      seen_high <= 1'b0;
      arrival   <= 1'b0;
    end else if (tick) begin
      if (pcnt == PW'(POLL_US - 1)) begin
        pcnt      <= '0;
        seen_high <= line_hi;
        arrival   <= seen_high && !line_hi;
      end else begin
        pcnt    <= pcnt + PW'(1);
        arrival <= 1'b0;
      end
    end else begin
      arrival <= 1'b0;
    end
  end
endmodule

// File: rtl/owrp_reset_presence.sv
module owrp_reset_presence #(
  parameter int CLKS_PER_US = 50,
  parameter int POLL_US     = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       od_sel,
  input  logic       line_in,
  output logic       drive_low,
  output logic [1:0] result,
  output logic       done,
  output logic       arrival,
  output logic       od_active
);
  logic [1:0] sync_q;
  logic       line_hi;
  logic       tick;
  logic       accept;
  logic       busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end
  assign line_hi = sync_q[1];

  owrp_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .tick  (tick)
  );

  owrp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .start     (start),
    .od_sel    (od_sel),
    .line_hi   (line_hi),
    .accept    (accept),
    .busy      (busy),
    .drive_low (drive_low),
    .done      (done),
    .result    (result),
    .od_active (od_active)
  );

  owrp_idle_watch #(.POLL_US(POLL_US)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .busy    (busy),
    .start   (start),
    .line_hi (line_hi),
    .arrival (arrival)
  );
endmodule

// File: rtl/owrp_checker.sv
module owrp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       line_hi,
  input logic       busy,
  input logic       drive_low,
  input logic [1:0] result,
  input logic       done,
  input logic       arrival,
  input logic       od_active
);
  a_r7_precheck_short: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !line_hi) |=> (!drive_low && done && result == 2'b10));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start)));

  a_r8_speed_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result != 2'b01) |-> !od_active);

  a_r9_no_arrival_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arrival |-> !busy);

  a_r9_arrival_single: assert property (@(posedge clk) disable iff (!rst_n)
    arrival |=> !arrival);

  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    result != 2'b11);

  a_r2_drive_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(start));
endmodule

bind owrp_reset_presence owrp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .line_hi   (line_hi),
  .busy      (busy),
  .drive_low (drive_low),
  .result    (result),
  .done      (done),
  .arrival   (arrival),
  .od_active (od_active)
);

// File: tb/owrp_reset_presence_test.sv
`timescale 1ns/1ps
module owrp_reset_presence_test;
  localparam int CPU  = 2;
  localparam int POLL = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       od_sel = 1'b0;
  logic       dev_low = 1'b0;
  logic       line_in;
  logic       drive_low;
  logic [1:0] result;
  logic       done;
  logic       arrival;
  logic       od_active;

  int errs = 0;
  int checks = 0;
  int arr_cnt = 0;

  always #2 clk = ~clk;

  assign line_in = !(drive_low || dev_low);

  owrp_reset_presence #(.CLKS_PER_US(CPU), .POLL_US(POLL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .od_sel(od_sel),
    .line_in(line_in), .drive_low(drive_low), .result(result),
    .done(done), .arrival(arrival), .od_active(od_active)
  );

  always @(negedge clk) if (arrival) arr_cnt++;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // One reset cycle with an optional device pulse (ps: start after release, pl: length, us)
  task automatic run_cycle(input logic od, input int ps, input int pl,
                           input logic [1:0] exp_res, input logic exp_od,
                           input logic poke, input string tag);
    int lowc = 0;
    int total = 0;
    int arr0 = arr_cnt;
    int lus = od ? 48 : 480;
    @(negedge clk);
    od_sel = od;
    start = 1'b1;
    fork
      begin
        do begin
          @(posedge clk);
          total++;
          @(negedge clk);
          start = poke && (total == 100);
          if (poke && total == 100) od_sel = ~od;
          if (drive_low) lowc++;
        end while (!done && total < 5000);
      end
      begin
        wait (drive_low == 1'b1);
        wait (drive_low == 1'b0);
        repeat (ps * CPU) @(negedge clk);
        if (pl > 0) begin
          dev_low = 1'b1;
          repeat (pl * CPU) @(negedge clk);
          dev_low = 1'b0;
        end
      end
    join
    od_sel = 1'b0;
    chk(result == exp_res, {tag, " R4 R5 R6 result"}, result, exp_res);
    chk(lowc == lus * CPU, {tag, " R2 low length"}, lowc, lus * CPU);
    chk(total == 2 * lus * CPU + 1, {tag, " R3 cycle length"}, total, 2 * lus * CPU + 1);
    chk(od_active == exp_od, {tag, " R8 od_active"}, od_active, exp_od);
    chk(arr_cnt == arr0, {tag, " R9 no arrival while busy"}, arr_cnt - arr0, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R11 done one cycle"}, done, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(drive_low == 0 && done == 0 && arrival == 0, "R1 outputs idle",
        {drive_low, done, arrival}, 0);
    chk(result == 2'b00, "R1 result", result, 0);
    chk(od_active == 0, "R1 od_active", od_active, 0);
  endtask

  task automatic t_precheck();
    int lowseen = 0;
    dev_low = 1'b1;
    repeat (6) @(negedge clk);
    od_sel = 1'b1;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    od_sel = 1'b0;
    if (drive_low) lowseen = 1;
    chk(done == 1'b1, "R7 done next cycle", done, 1);
    chk(result == 2'b10, "R7 short result", result, 2);
    chk(od_active == 1'b0, "R8 od cleared by precheck", od_active, 0);
    repeat (20) @(negedge clk) if (drive_low) lowseen = 1;
    chk(lowseen == 0, "R7 no reset pulse", lowseen, 0);
    dev_low = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    int guard = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(drive_low == 1'b1, "R11 start with done accepted", drive_low, 1);
    chk(done == 1'b0, "R11 done dropped", done, 0);
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(result == 2'b00, "R11 second cycle result", result, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_arrival();
    int arr0;
    repeat (200) @(negedge clk);
    arr0 = arr_cnt;
    dev_low = 1'b1;
    repeat (100 * CPU) @(negedge clk);
    dev_low = 1'b0;
    repeat (100 * CPU) @(negedge clk);
    chk(arr_cnt - arr0 == 1, "R9 one arrival", arr_cnt - arr0, 1);
    chk(result == 2'b00 && od_active == 0, "R9 arrival leaves result",
        result, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_cycle(1'b0, 30, 120, 2'b01, 1'b0, 1'b0, "std present");
    run_cycle(1'b0, 0, 0, 2'b00, 1'b0, 1'b0, "std none");
    run_cycle(1'b0, 20, 500, 2'b10, 1'b0, 1'b0, "std short");
    run_cycle(1'b0, 30, 240, 2'b01, 1'b0, 1'b0, "R6 long presence");
    run_cycle(1'b0, 60, 260, 2'b10, 1'b0, 1'b0, "R6 past last sample");
    run_cycle(1'b1, 2, 14, 2'b01, 1'b1, 1'b0, "od present");
    run_cycle(1'b1, 0, 0, 2'b00, 1'b0, 1'b0, "od none");
    run_cycle(1'b1, 2, 14, 2'b01, 1'b1, 1'b1, "R10 start while busy");
    run_cycle(1'b0, 30, 120, 2'b01, 1'b0, 1'b1, "R10 start while busy std");
    t_precheck();
    t_back_to_back();
    t_arrival();
    finish_run();
  end
endmodule